// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block produces the serial clock timing for an I2C master in two stages. The first stage divides the system clock by a 7-bit prescale value and yields an internal reference tick. The intended tick rate is 10 MHz, so software writes the system clock frequency in MHz divided by ten, rounded to the nearest integer. The second stage counts reference ticks to time the SCL high phase and the SCL low phase. Each phase has its own count, and both counts sit in one 16-bit divider word.

Software controls the block through two plain 16-bit words, a control word and a divider word. The control word carries the enable bit and the prescale field. At a 10 MHz tick, the per-phase count is 5,000,000 divided by the bus rate. Equal counts give a 50 % duty cycle. A count of 255 gives roughly 20 kHz, and the smallest legal count, 13, gives roughly 400 kHz.

The block has no data stream, so no valid/ready handshake applies; all pins are plain level control or status. It outputs:
- the reference tick,
- the SCL level,
- one-cycle strobes at each falling and rising SCL edge,
- a flag saying whether the divider word is legal,
- a fast-mode flag for downstream timing logic.

Clearing the enable bit and setting it again restarts the generator from its idle state.

Top module: `i2c_sclk_gen`

## Requirements
- R1: While enabled (control bit 15 = 1), `ref_tick` is high for one system clock in every P cycles, where P is control bits 6:0. Over one full SCL period it pulses exactly (low count + high count) times.
- R2: A prescale value of 0 behaves like 1: `ref_tick` is high on every enabled cycle.
- R3: The divider word's low byte is the SCL low-phase count L and its high byte is the high-phase count H, both in reference ticks. In steady running, `scl_level` stays low for L*max(P,1) cycles and high for H*max(P,1) cycles.
- R4: After the enable bit rises, `scl_level` starts high. Its first fall is seen H*max(P,1) rising clock edges after enabling.
- R5: `scl_fall` is high for exactly the first cycle in which `scl_level` reads 0, and `scl_rise` for exactly the first cycle in which it reads 1 again. The two strobes are never high together.
- R6: `div_ok` is 0 when either byte of the divider word is below 13. While it is 0, `scl_level` and the phase count hold and neither strobe fires.
- R7: `fast_mode` is 1 exactly when L + H < 100, that is, when the bus rate exceeds 100 kHz at a 10 MHz tick.
- R8: One cycle after the enable bit clears, `scl_level` is 1, both strobes are 0 and `ref_tick` is 0, from any phase.
- R9: After reset with the enable bit clear, `scl_level` = 1 and `ref_tick`, `scl_fall` and `scl_rise` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 16 | Bit 15 enable, bits 6:0 prescale; other bits unused |
| div_word | input | 16 | Bits 15:8 high-phase count, bits 7:0 low-phase count |
| ref_tick | output | 1 | Internal reference tick strobe |
| scl_level | output | 1 | Timed SCL level (1 = released/high) |
| scl_fall | output | 1 | One-cycle strobe at the start of each low phase |
| scl_rise | output | 1 | One-cycle strobe at the start of each high phase |
| div_ok | output | 1 | Divider word legal (both bytes at least 13) |
| fast_mode | output | 1 | Bus rate above 100 kHz |

## Verification
The hardest situation to reach is an illegal divider word written in the middle of a low phase. The hold must keep the line low and suppress both strobes; a missed hold would return the line high. The bench first waits for a falling strobe with a legal word. It then overwrites the low byte with an illegal value, watches the level for many cycles, and finally disables the block to confirm the restart path. Exact phase lengths are measured edge-to-edge from the enable point, so an off-by-one in either counter shows up as a miscount.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;

  typedef struct packed {
    logic [7:0] hi_cnt;
    logic [7:0] lo_cnt;
  } div_fields_t;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int PSC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] last;

  always_comb begin
    if (psc == '0) last = '0;
    else           last = psc - 1'b1;
  end

  assign tick = en && (cnt_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!en || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && last != '0) |=> (!tick || !$stable(psc)));

  // R8
  tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $stable(en)) |-> !tick);

endmodule

// File: rtl/sclk_div_check.sv
module sclk_div_check #(
  parameter int CNT_W    = 8,
  parameter int MIN_CNT  = 13,
  parameter int FAST_SUM = 100
) (
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  output logic             ok,
  output logic             fast
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_CNT);
  localparam logic [SUM_W-1:0] FAST_V = SUM_W'(FAST_SUM);

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = {1'b0, lo_cnt} + {1'b0, hi_cnt};
    ok   = (lo_cnt >= MIN_V) && (hi_cnt >= MIN_V);
    fast = (sum < FAST_V);
  end

endmodule

// File: rtl/sclk_phase_timer.sv
module sclk_phase_timer
  import i2c_sclk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ok,
  input  logic             tick,
  input  logic [CNT_W-1:0] lo_cnt,
  input  logic [CNT_W-1:0] hi_cnt,
  output logic             level,
  output logic             fall,
  output logic             rise
);
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic             wrap;

  always_comb begin
    limit = (phase_q == PH_HIGH) ? hi_cnt : lo_cnt;
    wrap  = (cnt_q >= (limit - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_HIGH;
      cnt_q   <= '0;
      fall    <= 1'b0;
      rise    <= 1'b0;
    end else begin
      fall <= 1'b0;
      rise <= 1'b0;
      if (!en) begin
        phase_q <= PH_HIGH;
        cnt_q   <= '0;
      end else if (ok && tick) begin
        if (wrap) begin
          cnt_q <= '0;
          if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            fall    <= 1'b1;
          end else begin
            phase_q <= PH_HIGH;
            rise    <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level = (phase_q == PH_HIGH);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall, rise}));

  // R5
  fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> (!level && $past(level)));

  // R8
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (level && !fall && !rise));

  // R6
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !ok) |=> ($stable(level) && !fall && !rise));

endmodule

// File: rtl/i2c_sclk_gen.sv
module i2c_sclk_gen
  import i2c_sclk_pkg::*;
#(
  parameter int PSC_W    = 7,
  parameter int EN_BIT   = 15,
  parameter int MIN_CNT  = 13,
  parameter int FAST_SUM = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl_word,
  input  logic [15:0] div_word,
  output logic        ref_tick,
  output logic        scl_level,
  output logic        scl_fall,
  output logic        scl_rise,
  output logic        div_ok,
  output logic        fast_mode
);
  localparam int CNT_W = 8;

  div_fields_t      div_f;
  logic             enable;
  logic [PSC_W-1:0] psc;

  assign div_f  = div_fields_t'(div_word);
  assign enable = ctrl_word[EN_BIT];
  assign psc    = ctrl_word[PSC_W-1:0];

  sclk_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (enable),
    .psc   (psc),
    .tick  (ref_tick)
  );

  sclk_div_check #(
    .CNT_W    (CNT_W),
    .MIN_CNT  (MIN_CNT),
    .FAST_SUM (FAST_SUM)
  ) u_chk (
    .lo_cnt (div_f.lo_cnt),
    .hi_cnt (div_f.hi_cnt),
    .ok     (div_ok),
    .fast   (fast_mode)
  );

  sclk_phase_timer #(.CNT_W(CNT_W)) u_ph (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .ok     (div_ok),
    .tick   (ref_tick),
    .lo_cnt (div_f.lo_cnt),
    .hi_cnt (div_f.hi_cnt),
    .level  (scl_level),
    .fall   (scl_fall),
    .rise   (scl_rise)
  );

endmodule

// File: tb/i2c_sclk_gen_tb.sv
module i2c_sclk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {prescale, low count, high count}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1, 8'd13, 8'd13},
    {8'd2, 8'd20, 8'd30},
    {8'd3, 8'd50, 8'd50},
    {8'd1, 8'd60, 8'd45},
    {8'd0, 8'd15, 8'd14},
    {8'd1, 8'd12, 8'd40},
    {8'd1, 8'd13, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic [15:0] div_word = '0;
  logic ref_tick, scl_level, scl_fall, scl_rise, div_ok, fast_mode;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_sclk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .div_word(div_word),
    .ref_tick(ref_tick), .scl_level(scl_level), .scl_fall(scl_fall),
    .scl_rise(scl_rise), .div_ok(div_ok), .fast_mode(fast_mode)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait until scl_level reads want; returns edge count, strobe seen, ticks
  task automatic wait_level(input logic want, output int n, output logic stb,
                            output logic other, inout int ticks);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (ref_tick) ticks++;
    end while (scl_level != want && n < 5000);
    stb   = want ? scl_rise : scl_fall;
    other = want ? scl_fall : scl_rise;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n, ticks, pe, lo, hi;
    logic stb, oth;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9 level", scl_level, 1);
    check("R9 tick", ref_tick, 0);
    check("R9 strobes", scl_fall | scl_rise, 0);

    for (int v = 0; v < NVEC; v++) begin
      pe = (VEC[v][23:16] == 0) ? 1 : int'(VEC[v][23:16]);
      lo = int'(VEC[v][15:8]);
      hi = int'(VEC[v][7:0]);
      ctrl_word = 16'h0000;
      repeat (2) @(negedge clk);
      div_word  = {VEC[v][7:0], VEC[v][15:8]};
      ctrl_word = {1'b1, 8'h00, VEC[v][22:16]};
      #1;
      check("R6 div_ok", div_ok, (lo >= 13 && hi >= 13) ? 1 : 0);
      check("R7 fast_mode", fast_mode, (lo + hi < 100) ? 1 : 0);
      if (lo >= 13 && hi >= 13) begin
        ticks = 0;
        wait_level(1'b0, n, stb, oth, ticks);
        check("R4 first fall", n, hi * pe);
        check("R5 fall strobe", {stb, oth}, 2);
        ticks = 0;
        wait_level(1'b1, n, stb, oth, ticks);
        check("R3 low phase", n, lo * pe);
        check("R5 rise strobe", {stb, oth}, 2);
        wait_level(1'b0, n, stb, oth, ticks);
        check("R3 high phase", n, hi * pe);
        check(pe == 1 && VEC[v][23:16] == 0 ? "R2 ticks" : "R1 ticks", ticks, lo + hi);
        @(posedge clk); @(negedge clk);
        check("R5 strobe one cycle", scl_fall, 0);
      end else begin
        n = 0;
        for (int c = 0; c < 150; c++) begin
          @(posedge clk); @(negedge clk);
          if (scl_level != 1'b1 || scl_fall || scl_rise) n++;
        end
        check("R6 invalid hold idle", n, 0);
      end
    end

    // R6 invalid word mid low phase, then R8 disable
    ctrl_word = 16'h0000;
    repeat (2) @(negedge clk);
    div_word  = {8'd20, 8'd20};
    ctrl_word = 16'h8001;
    ticks = 0;
    wait_level(1'b0, n, stb, oth, ticks);
    check("R4 fall before hold", n, 20);
    repeat (5) @(negedge clk);
    div_word = {8'd20, 8'd5};
    #1;
    check("R6 div_ok low", div_ok, 0);
    n = 0;
    for (int c = 0; c < 150; c++) begin
      @(posedge clk); @(negedge clk);
      if (scl_level != 1'b0 || scl_fall || scl_rise) n++;
    end
    check("R6 hold in low phase", n, 0);
    ctrl_word = 16'h0001;
    @(posedge clk); @(negedge clk);
    check("R8 level after disable", scl_level, 1);
    check("R8 tick after disable", ref_tick, 0);
    check("R8 strobes after disable", scl_fall | scl_rise, 0);
    // R8 restart: re-enable with legal word
    div_word  = {8'd14, 8'd16};
    ctrl_word = 16'h8002;
    ticks = 0;
    wait_level(1'b0, n, stb, oth, ticks);
    check("R8 restart first fall", n, 28);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule